// File: doc/BRIEF.md
# PHY Management Interrupt Controller

This block collects seven event pulses from a physical-layer transceiver into sticky status bits and drives a single active-low interrupt line. Each event has an enable bit in a separate enable register. The interrupt line goes low while any status bit that is both set and enabled exists. The enable bits only gate the line. A status bit latches whether or not its enable bit is set.

Software works through a small register port. It reads the status register to find the cause of an interrupt, and that read also clears the status bits. The enable register is read/write. Bit 0 of both registers is reserved. Events occupy bits 7 down to 1 in this fixed order:
- bit 7: energy detect
- bit 6: auto-negotiation done
- bit 5: remote fault
- bit 4: link drop
- bit 3: link-partner acknowledge
- bit 2: parallel-detect fault
- bit 1: page received

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the enable register reads 0x00 and irq_n is 1.
- R2: A one-cycle pulse on evt_i[k] (k = 0..6) sets status bit k+1. The bit stays set until the status register is read.
- R3: The status register is at address 0 and the enable register is at address 1. Other addresses read 0x00 and ignore writes.
- R4: A status read returns the held bits in rd_data_o in the same cycle, combinationally. It clears all status bits from the next cycle on.
- R5: An event in the same cycle as a status read leaves its bit set after the read. The read returns the value held before the event.
- R6: irq_n is 0 whenever (status & enable) is nonzero, and 1 otherwise. It follows the registers combinationally.
- R7: A status bit latches even when its enable bit is 0. Setting the enable bit later drives irq_n low.
- R8: Writes to address 1 store bits 7..1 of wr_data_i. Bit 0 of both registers always reads 0.
- R9: Writes to address 0 have no effect, because the status register is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | Event pulses; evt_i[k] maps to status bit k+1 |
| addr_i | input | ADDR_W | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid in the strobe cycle |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets the following corner cases:
- An event that coincides with a clearing read. A design that gives the clear priority would lose that event.
- An event that latches while its enable bit is 0. A design that masks the latch would never raise the interrupt once the enable bit is set later.
- Writes to the read-only status register and to the reserved bit 0, which would leak into read data if decoded loosely.
- Read data returned in the same cycle as the strobe, which catches a design that clears the status bits before they are returned.

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
  parameter int N_SRC  = 7,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [N_SRC:0]    wr_data_i,
  output logic [N_SRC:0]    rd_data_o,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] A_STAT = '0;
  localparam logic [ADDR_W-1:0] A_ENAB = ADDR_W'(1);

  logic [N_SRC-1:0] stat_q, enab_q;
  logic             stat_rd, enab_wr;

  assign stat_rd = rd_en_i && (addr_i == A_STAT);
  assign enab_wr = wr_en_i && (addr_i == A_ENAB);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       stat_q <= '0;
    else if (stat_rd) stat_q <= evt_i;
    else              stat_q <= stat_q | evt_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       enab_q <= '0;
    else if (enab_wr) enab_q <= wr_data_i[N_SRC:1];

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (addr_i == A_STAT)      rd_data_o = {stat_q, 1'b0};
      else if (addr_i == A_ENAB) rd_data_o = {enab_q, 1'b0};
    end
  end

  assign irq_n = ~|(stat_q & enab_q);

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_i |=> ((stat_q & $past(evt_i)) == $past(evt_i)));  // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));  // R2
  AST_CLR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (stat_q == $past(evt_i)));  // R5
  AST_ENAB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enab_wr |=> $stable(enab_q));  // R9
  AST_RSVD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[0] == 1'b0);  // R8
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> irq_n);  // R6
endmodule

// File: tb/phy_irq_ctrl_tb.sv
module phy_irq_ctrl_tb;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic [6:0] evt = 0;
  logic [4:0] addr = 0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq_n;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  phy_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr),
    .rd_en_i(rd), .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_n(irq_n));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on negedge, sample before next posedge
  task automatic rdreg(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wrreg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rdreg(0, v); chk("R1 status", v, 8'h00);
    rdreg(1, v); chk("R1 enable", v, 8'h00);
    chk("R1 irq", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_latch_masked;
    logic [7:0] v;
    pulse(7'b1000001);
    chk("R7 irq masked", {7'd0, irq_n}, 8'h01);
    wrreg(1, 8'h02);
    chk("R7 irq after enable", {7'd0, irq_n}, 8'h00);
    rdreg(0, v); chk("R2 R4 status", v, 8'h82);
    chk("R6 irq after clear", {7'd0, irq_n}, 8'h01);
    rdreg(0, v); chk("R4 cleared", v, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    pulse(7'b0000100);
    @(negedge clk); addr = 0; rd = 1; evt = 7'b0010000; #1 v = rdata;
    @(negedge clk); rd = 0; evt = 0;
    chk("R5 read value", v, 8'h08);
    rdreg(0, v); chk("R5 kept event", v, 8'h20);
  endtask

  task automatic t_enable_rw;
    logic [7:0] v;
    wrreg(1, 8'hFF);
    rdreg(1, v); chk("R8 enable rw", v, 8'hFE);
    wrreg(0, 8'hFF);
    rdreg(0, v); chk("R9 status ro", v, 8'h00);
    wrreg(3, 8'h00);
    rdreg(1, v); chk("R3 bad addr write", v, 8'hFE);
    rdreg(3, v); chk("R3 bad addr read", v, 8'h00);
    pulse(7'b0100000);
    chk("R6 irq low", {7'd0, irq_n}, 8'h00);
    wrreg(1, 8'h00);
    chk("R6 irq gated", {7'd0, irq_n}, 8'h01);
    rdreg(0, v); chk("R2 bit6", v, 8'h40);
  endtask

  initial begin
    #(CLK_P*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_latch_masked();
    t_collide();
    t_enable_rw();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule